// File: doc/BRIEF.md
# Endian-aware instruction fill reorderer

This block sits on the path from the memory bus into the instruction cache fill port. Each fill beat carries two 32-bit instruction words. For every beat the block decides whether the fetched words come from a little-endian region. If they do, it reverses the byte order of each word, so the cache only ever receives big-endian instructions. The fetch address is never altered. Only the byte lanes of the data move.

Two sources can supply the endian decision. When instruction translation is on, the page endian bit that arrives with the translation result is used. When translation is off, the block uses a 32-bit region map that it holds itself. Each bit of the map covers one region, picked by the top five bits of the fetch address. Software writes the map through a write-enable/data port and can read it back. A write that changes the map raises a one-cycle invalidate request, so that the cache can drop instructions that were stored under the old ordering.

The map's change tracking is a two-state machine. `RG_STEADY` is the idle state, with no invalidate pending. `RG_FLUSH` is the state in which the invalidate request is driven. The machine moves from `RG_STEADY` to `RG_FLUSH` on a write whose data differs from the current map. It stays in `RG_FLUSH` when the next cycle brings another such write. It returns from `RG_FLUSH` to `RG_STEADY` otherwise.

Top module: `edn_fill_reorder`

## Requirements
- R1: After reset, `icache_valid_o`, `icache_data_o` and `inval_req_o` are all zero, and the region map reads back as all zeros (every region big endian).
- R2: When `xlat_on_i` is 1, `page_le_i` alone decides the ordering: 1 means little endian and 0 means big endian, whatever the region map holds.
- R3: When `xlat_on_i` is 0, region map bit `fill_addr_i[31:27]` decides the ordering: 1 means little endian. `page_le_i` has no effect.
- R4: For a little-endian beat, each 32-bit word (bits [31:0] and bits [63:32]) has its bytes fully reversed on its own. Output byte k of a word equals input byte 3-k of that same word, where byte 0 is bits [7:0] of the word. Words never trade places.
- R5: For a big-endian beat, `icache_data_o` equals `fill_data_i` unchanged.
- R6: `icache_valid_o` equals `fill_valid_i` of the previous cycle. `icache_data_o` shows the reordered beat of the previous cycle whenever that beat was valid.
- R7: In a cycle after one with `fill_valid_i` low, `icache_data_o` keeps its previous value.
- R8: A cycle with `rgn_we_i` high loads `rgn_wdata_i` into the map, and `rgn_rdata_o` shows it from the next cycle on. A fill in that same cycle still uses the old map. Without a write the map holds.
- R9: `inval_req_o` is high for exactly the cycle after a write whose data differs from the current map. A write of the current value gives no pulse. Differing writes on consecutive cycles give consecutive pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid_i | input | 1 | Fill beat valid |
| fill_addr_i | input | 32 | Fetch address of the beat |
| xlat_on_i | input | 1 | Instruction translation enabled |
| page_le_i | input | 1 | Page endian bit from translation (1 = little endian) |
| fill_data_i | input | 64 | Fill beat from memory, two instruction words |
| rgn_we_i | input | 1 | Region map write enable |
| rgn_wdata_i | input | 32 | Region map write data |
| rgn_rdata_o | output | 32 | Region map read-back |
| icache_valid_o | output | 1 | Beat valid toward the cache |
| icache_data_o | output | 64 | Reordered beat toward the cache |
| inval_req_o | output | 1 | One-cycle instruction cache invalidate request |

## Verification
The bench builds the block with its default parameters: five region-select bits, which gives a 32-region map, and a 64-bit beat of two 32-bit words. With these defaults every region bit can be reached through a random 32-bit fetch address. A byte swap that crosses words, or that mixes up the words, shows up in the upper lane. Directed writes cover the write that changes the map, the write that does not, back-to-back writes, and a fill in the same cycle as a map write. Random traffic then mixes both translation modes with sparse map writes.

// File: rtl/edn_pkg.sv
package edn_pkg;

    typedef enum logic [0:0] {
        RG_STEADY = 1'b0,
        RG_FLUSH  = 1'b1
    } rgn_state_e;

endpackage

// File: rtl/edn_region_ctl.sv
module edn_region_ctl
    import edn_pkg::*;
#(
    parameter int unsigned NUM_RGN = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_i,
    input  logic [NUM_RGN-1:0] wdata_i,
    output logic [NUM_RGN-1:0] map_o,
    output logic               inval_o
);

    logic [NUM_RGN-1:0] map_q;
    rgn_state_e         state_q;
    rgn_state_e         state_d;
    logic               changed;

    assign changed = we_i && (wdata_i != map_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q <= '0;
        end else if (we_i) begin
            map_q <= wdata_i;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RG_STEADY;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RG_STEADY: state_d = changed ? RG_FLUSH : RG_STEADY;
            RG_FLUSH:  state_d = changed ? RG_FLUSH : RG_STEADY;
            default:   state_d = RG_STEADY;
        endcase
    end

    // outputs
    always_comb begin
        inval_o = 1'b0;
        unique case (state_q)
            RG_STEADY: inval_o = 1'b0;
            RG_FLUSH:  inval_o = 1'b1;
            default:   inval_o = 1'b0;
        endcase
    end

    assign map_o = map_q;

    AST_INVAL_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && (wdata_i != map_o)) |=> inval_o);                 // R9
    AST_NO_SPURIOUS_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_i && (wdata_i != map_o)) |=> !inval_o);               // R9
    AST_MAP_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (map_o == $past(wdata_i)));                       // R8
    AST_MAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(map_o));                                 // R8

endmodule

// File: rtl/edn_endian_sel.sv
module edn_endian_sel #(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned RGN_BITS = 5,
    localparam int unsigned NUM_RGN = 1 << RGN_BITS
) (
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               xlat_on_i,
    input  logic               page_le_i,
    input  logic [NUM_RGN-1:0] map_i,
    output logic               le_o
);

    logic [RGN_BITS-1:0] rgn_idx;
    logic                map_le;

    assign rgn_idx = addr_i[ADDR_W-1 -: RGN_BITS];
    assign map_le  = map_i[rgn_idx];

    always_comb begin
        if (xlat_on_i) begin
            le_o = page_le_i;
        end else begin
            le_o = map_le;
        end
    end

endmodule

// File: rtl/edn_lane_swap.sv
module edn_lane_swap #(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned WORD_W = 32,
    parameter int unsigned WORDS  = 2,
    localparam int unsigned BPW    = WORD_W / BYTE_W,
    localparam int unsigned BEAT_W = WORD_W * WORDS
) (
    input  logic              le_i,
    input  logic [BEAT_W-1:0] data_i,
    output logic [BEAT_W-1:0] data_o
);

    logic [BEAT_W-1:0] swapped;

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        for (genvar b = 0; b < BPW; b++) begin : g_byte
            assign swapped[w*WORD_W + b*BYTE_W +: BYTE_W] =
                data_i[w*WORD_W + (BPW-1-b)*BYTE_W +: BYTE_W];
        end
    end

    assign data_o = le_i ? swapped : data_i;

endmodule

// File: rtl/edn_fill_reorder.sv
module edn_fill_reorder #(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned RGN_BITS = 5,
    parameter int unsigned WORD_W   = 32,
    parameter int unsigned WORDS    = 2,
    localparam int unsigned NUM_RGN = 1 << RGN_BITS,
    localparam int unsigned BEAT_W  = WORD_W * WORDS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fill_valid_i,
    input  logic [ADDR_W-1:0]  fill_addr_i,
    input  logic               xlat_on_i,
    input  logic               page_le_i,
    input  logic [BEAT_W-1:0]  fill_data_i,
    input  logic               rgn_we_i,
    input  logic [NUM_RGN-1:0] rgn_wdata_i,
    output logic [NUM_RGN-1:0] rgn_rdata_o,
    output logic               icache_valid_o,
    output logic [BEAT_W-1:0]  icache_data_o,
    output logic               inval_req_o
);

    logic [NUM_RGN-1:0] map;
    logic               le;
    logic [BEAT_W-1:0]  ordered;
    logic               valid_q;
    logic [BEAT_W-1:0]  data_q;

    edn_region_ctl #(.NUM_RGN(NUM_RGN)) u_rgn (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (rgn_we_i),
        .wdata_i (rgn_wdata_i),
        .map_o   (map),
        .inval_o (inval_req_o)
    );

    edn_endian_sel #(.ADDR_W(ADDR_W), .RGN_BITS(RGN_BITS)) u_sel (
        .addr_i    (fill_addr_i),
        .xlat_on_i (xlat_on_i),
        .page_le_i (page_le_i),
        .map_i     (map),
        .le_o      (le)
    );

    edn_lane_swap #(.BYTE_W(8), .WORD_W(WORD_W), .WORDS(WORDS)) u_swap (
        .le_i   (le),
        .data_i (fill_data_i),
        .data_o (ordered)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else begin
            valid_q <= fill_valid_i;
            if (fill_valid_i) begin
                data_q <= ordered;
            end
        end
    end

    assign icache_valid_o = valid_q;
    assign icache_data_o  = data_q;
    assign rgn_rdata_o    = map;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid_i |=> icache_valid_o);                          // R6
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_valid_i |=> !icache_valid_o);                        // R6
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_valid_i |=> $stable(icache_data_o));                 // R7
    AST_BE_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid_i && xlat_on_i && !page_le_i) |=>
            (icache_data_o == $past(fill_data_i)));                // R2
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (!icache_valid_o && !inval_req_o));             // R1

endmodule

// File: tb/tb_edn_fill_reorder.sv
`timescale 1ns/1ps
module tb_edn_fill_reorder;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        fill_valid_i;
    logic [31:0] fill_addr_i;
    logic        xlat_on_i;
    logic        page_le_i;
    logic [63:0] fill_data_i;
    logic        rgn_we_i;
    logic [31:0] rgn_wdata_i;
    logic [31:0] rgn_rdata_o;
    logic        icache_valid_o;
    logic [63:0] icache_data_o;
    logic        inval_req_o;

    always #4 clk = ~clk;

    edn_fill_reorder dut (
        .clk(clk), .rst_n(rst_n), .fill_valid_i(fill_valid_i), .fill_addr_i(fill_addr_i),
        .xlat_on_i(xlat_on_i), .page_le_i(page_le_i), .fill_data_i(fill_data_i),
        .rgn_we_i(rgn_we_i), .rgn_wdata_i(rgn_wdata_i), .rgn_rdata_o(rgn_rdata_o),
        .icache_valid_o(icache_valid_o), .icache_data_o(icache_data_o), .inval_req_o(inval_req_o)
    );

    int    n_vec  = 0;
    int    n_fail = 0;
    bit    done   = 0;

    // reference state
    logic [31:0] m_map   = '0;
    logic        m_valid = 1'b0;
    logic [63:0] m_data  = '0;
    logic        m_inval = 1'b0;
    string       m_dtag  = "R1";
    string       m_vtag  = "R1";

    function automatic logic [31:0] rev32(input logic [31:0] x);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) r[8*i +: 8] = x[8*(3-i) +: 8];
        return r;
    endfunction

    task automatic check(input string tag, input bit ok, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check(m_vtag, icache_valid_o === m_valid, {63'd0, icache_valid_o}, {63'd0, m_valid});
        check(m_dtag, icache_data_o === m_data, icache_data_o, m_data);
        check(m_vtag == "R1" ? "R1" : "R9", inval_req_o === m_inval, {63'd0, inval_req_o}, {63'd0, m_inval});
        check(m_vtag == "R1" ? "R1" : "R8", rgn_rdata_o === m_map, {32'd0, rgn_rdata_o}, {32'd0, m_map});
    endtask

    // one cycle: compare outputs of the last edge, drive new inputs, advance model
    task automatic step(input bit vld, input logic [31:0] addr, input bit xl, input bit pg,
                        input logic [63:0] d, input bit we, input logic [31:0] wd);
        bit le;
        @(negedge clk);
        compare_all();
        fill_valid_i = vld; fill_addr_i = addr; xlat_on_i = xl; page_le_i = pg;
        fill_data_i = d; rgn_we_i = we; rgn_wdata_i = wd;
        le = xl ? pg : m_map[addr[31:27]];
        m_valid = vld;
        m_vtag  = "R6";
        if (vld) begin
            m_data = le ? {rev32(d[63:32]), rev32(d[31:0])} : d;
            if (we && wd != m_map) m_dtag = "R8";
            else if (xl)           m_dtag = "R2";
            else                   m_dtag = le ? "R4" : "R3";
        end else begin
            m_dtag = "R7";
        end
        m_inval = we && (wd != m_map);
        if (we) m_map = wd;
    endtask

    localparam logic [63:0] PAT = 64'h0011_2233_4455_6677;
    localparam logic [63:0] PAT_SW = 64'h3322_1100_7766_5544;

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        fill_valid_i = 0; fill_addr_i = '0; xlat_on_i = 0; page_le_i = 0;
        fill_data_i = '0; rgn_we_i = 0; rgn_wdata_i = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: first step compares the reset state
        step(0, 0, 0, 0, 0, 0, 0);
        // R5: big endian pass-through with empty map
        step(1, 32'hF800_0000, 0, 0, PAT, 0, 0);
        // R9: changing write pulses
        step(0, 0, 0, 0, 0, 1, 32'h8000_0001);
        // R9: same value, no pulse
        step(0, 0, 0, 0, 0, 1, 32'h8000_0001);
        // R3/R4: region 31 little endian
        step(1, 32'hF800_0010, 0, 1'b0, PAT, 0, 0);
        // R3: region 0 little endian, region 1 big endian, page bit ignored
        step(1, 32'h0000_0100, 0, 1'b0, PAT, 0, 0);
        step(1, 32'h0800_0000, 0, 1'b1, PAT, 0, 0);
        // R2: translation on overrides map
        step(1, 32'hF800_0000, 1, 0, PAT, 0, 0);
        step(1, 32'h0800_0000, 1, 1, PAT, 0, 0);
        // R7: hold with valid low
        step(0, 32'hF800_0000, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0);
        // R8: fill in same cycle as write uses old map (region 1 BE)
        step(1, 32'h0800_0000, 0, 0, PAT, 1, 32'h0000_0002);
        step(1, 32'h0800_0000, 0, 0, PAT, 0, 0);
        // R9: back-to-back differing writes
        step(0, 0, 0, 0, 0, 1, 32'h1234_5678);
        step(0, 0, 0, 0, 0, 1, 32'h8765_4321);
        step(0, 0, 0, 0, 0, 1, 32'h8765_4321);
        step(0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        // R4: spot check of the expected swap constant
        check("R4", {rev32(PAT[63:32]), rev32(PAT[31:0])} == PAT_SW, PAT_SW, PAT_SW);
        // random traffic
        for (int i = 0; i < 2000; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0] | r[1], $urandom, r[2], r[3], {$urandom, $urandom},
                 (r[7:4] == 4'd0), (r[8] ? rgn_rdata_o : $urandom));
        end
        step(0, 0, 0, 0, 0, 0, 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule